// File: doc/BRIEF.md
# MII management register controller

This block lets a host reach the registers of an Ethernet PHY over the two-wire serial management bus. The host sees six 16-bit registers on a simple strobe-based register port. It loads a combined PHY/register address first. Loading the write-data register then issues a management write. Raising bit 0 of the command register issues a management read. The block generates the management clock from the system clock and shifts out each frame. For reads it releases the data line during the turnaround and captures the PHY's answer. It reports progress through a small indicator field.

Each frame is 64 bit-times long and is sent most significant bit first. It consists of 32 ones, the start pattern 01, an opcode (01 write, 10 read), the 5-bit PHY address, the 5-bit register number, two turnaround bits and 16 data bits. During a write the block drives turnaround 10. During a read it stops driving from the first turnaround bit to the end of the frame. A soft-reset bit in the configuration register aborts any frame at once and keeps the bus idle while it is set.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the configuration register (offset 0x20) reads 0x001C, the indicator (offset 0x34) and read data (offset 0x30) read 0, and MDC and the data-line enable are low.
- R2: The address register (offset 0x28) stores the PHY address in bits 12:8 and the register number in bits 4:0; all other bits read back as 0.
- R3: A write to the write-data register (offset 0x2C) while idle starts a write frame; from the next cycle the indicator reads 3 (bit0 busy, bit1 write) for exactly 128*H cycles, then 0.
- R4: A write frame drives 32 ones, 01, opcode 01, PHY address, register number, turnaround 10 and the 16 written data bits, MSB first, with the line enabled throughout; the line changes only while MDC is low.
- R5: MDC stays low for H system cycles and then high for H cycles in every bit-time, where H is the configuration field in bits 4:2 plus one.
- R6: Writing the command register (offset 0x24) with bit0 = 1 while that bit reads 0 starts a read frame with opcode 10. The indicator reads 5 (bit0 busy, bit2 read). The enable drops from the first turnaround bit (bit-time 46) to the end of the frame.
- R7: During a read the line is sampled on each MDC rising edge of bit-times 48 to 63, MSB first. The 16-bit result appears at offset 0x30 once the indicator is 0, and a line left high yields 0xFFFF unchanged.
- R8: Writing bit0 = 1 to the command register while it already reads 1 starts nothing; it must be cleared and set again to issue another read.
- R9: A start request that arrives while a frame is running is ignored, and the running frame continues unaltered.
- R10: Setting configuration bit 15 ends any frame one cycle after the write takes effect: the indicator reads 0 and MDC and the enable are low. Start requests are ignored while the bit is set. After it is cleared, frames run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A start request takes effect at the clock edge that captures it, so the indicator turns nonzero in the very next cycle. That cycle is counted as k = 0. Bit-time b then occupies cycles 2Hb to 2Hb+2H-1, and MDC is high in the upper half of that window. The indicator and read data are due at k = 128H. A soft reset shows one cycle after the configuration write lands. The reference model in the bench derives MDC, the line value, the enable and the indicator from k alone. It compares them one nanosecond after every falling clock edge. It also drives the PHY reply from k, so that the reply is stable across each rising MDC edge.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int PRE_LEN = 32,
  parameter int SEL_W   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [5:0] A_CFG = 6'h20, A_CMD = 6'h24, A_ADR = 6'h28,
                         A_WD  = 6'h2C, A_RD  = 6'h30, A_IND = 6'h34;

  logic                 srst, rd_cmd, busy, is_read;
  logic [SEL_W-1:0]     div_sel, cnt;
  logic [4:0]           phy_a, reg_a;
  logic [15:0]          wdata, rdata, rshift;
  logic [IDX_W-1:0]     idx;
  logic [FRAME_LEN-1:0] frame;

  wire wr_cfg   = reg_wr && reg_addr == A_CFG;
  wire wr_cmd   = reg_wr && reg_addr == A_CMD;
  wire wr_adr   = reg_wr && reg_addr == A_ADR;
  wire wr_wd    = reg_wr && reg_addr == A_WD;
  wire can_go   = !busy && !srst;
  wire start_wr = wr_wd && can_go;
  wire start_rd = wr_cmd && reg_wdata[0] && !rd_cmd && can_go;
  wire [IDX_W-1:0] bitpos = LAST_IDX - idx;

  assign mdio_o  = busy && frame[bitpos];
  assign mdio_oe = busy && !(is_read && idx >= TA_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst    <= 1'b0;
      div_sel <= '1;
      rd_cmd  <= 1'b0;
      phy_a   <= '0;
      reg_a   <= '0;
      wdata   <= '0;
    end else begin
      if (wr_cfg) begin
        srst    <= reg_wdata[15];
        div_sel <= reg_wdata[2 +: SEL_W];
      end
      if (wr_cmd) rd_cmd <= reg_wdata[0];
      if (wr_adr) begin
        phy_a <= reg_wdata[12:8];
        reg_a <= reg_wdata[4:0];
      end
      if (wr_wd) wdata <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_read <= 1'b0;
      mdc     <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      frame   <= '0;
      rshift  <= '0;
      rdata   <= '0;
    end else if (srst) begin
      busy <= 1'b0;
      mdc  <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
    end else if (start_wr || start_rd) begin
      busy    <= 1'b1;
      is_read <= start_rd;
      mdc     <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      frame   <= {{PRE_LEN{1'b1}}, 2'b01, start_rd ? 2'b10 : 2'b01, phy_a, reg_a,
                  start_rd ? 2'b11 : 2'b10, start_rd ? 16'hFFFF : reg_wdata};
    end else if (busy) begin
      if (cnt == div_sel) begin
        cnt <= '0;
        mdc <= !mdc;
        if (!mdc) begin
          if (is_read && idx >= DATA_IDX) rshift <= {rshift[14:0], mdio_i};
        end else if (idx == LAST_IDX) begin
          busy <= 1'b0;
          if (is_read) rdata <= rshift;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {srst, 15'(div_sel) << 2};
      A_CMD:   reg_rdata = {15'b0, rd_cmd};
      A_ADR:   reg_rdata = {3'b0, phy_a, 3'b0, reg_a};
      A_WD:    reg_rdata = wdata;
      A_RD:    reg_rdata = rdata;
      A_IND:   reg_rdata = {13'b0, busy && is_read, busy && !is_read, busy};
      default: reg_rdata = '0;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R1
  AST_LINE_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4
  AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_WD && !busy && !srst) |=> (busy && !is_read)); // R3
  AST_READ_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CMD && rd_cmd && !busy) |=> !busy); // R8
  AST_SRST_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !mdc)); // R10
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i = 1'b1;
  logic [5:0]  reg_addr = 6'h34;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, failures = 0;
  logic [15:0] v;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Reference model: all outputs derived from the cycle count k since the start edge.
  task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] data, input int h, input logic [15:0] resp,
                           input bit absent, input int poke);
    logic [63:0] ef;
    ef = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b11 : 2'b10,
          rd ? 16'hFFFF : data};
    for (int k = 0; k <= 128 * h; k++) begin
      int b;
      bit exp_oe;
      b = k / (2 * h);
      if (k == poke) begin
        reg_wr = 1'b1; reg_addr = 6'h2C; reg_wdata = 16'h1234;
      end else begin
        reg_wr = 1'b0; reg_addr = 6'h34;
      end
      if (k < 128 * h && rd && !absent && b >= 48) mdio_i = resp[15 - (b - 48)];
      else if (k < 128 * h && rd && !absent && b == 47) mdio_i = 1'b0;
      else mdio_i = 1'b1;
      #1;
      if (k < 128 * h) begin
        exp_oe = !(rd && b >= 46);
        chk("R5 mdc", mdc, ((k / h) % 2));
        chk(rd ? "R6 oe" : "R4 oe", mdio_oe, exp_oe);
        if (exp_oe) chk("R4 mdio", mdio_o, ef[63 - b]);
        if (k != poke) chk("R3 indicator", reg_rdata, rd ? 5 : 3);
      end else begin
        chk("R3 indicator done", reg_rdata, 0);
        chk("R5 mdc idle", mdc, 0);
        chk("R1 oe idle", mdio_oe, 0);
      end
      @(negedge clk);
    end
    reg_wr = 1'b0;
    mdio_i = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(6'h20, v); chk("R1 cfg reset", v, 16'h001C);
    peek(6'h34, v); chk("R1 indicator reset", v, 0);
    peek(6'h30, v); chk("R1 rdata reset", v, 0);
    chk("R1 mdc reset", mdc, 0);
    chk("R1 oe reset", mdio_oe, 0);

    reg_write(6'h28, 16'hFFFF);
    peek(6'h28, v); chk("R2 addr fields", v, 16'h1F1F);
    reg_write(6'h28, 16'h1105);
    peek(6'h28, v); chk("R2 addr value", v, 16'h1105);

    reg_write(6'h2C, 16'hA5C3);
    run_frame(1'b0, 5'h11, 5'h05, 16'hA5C3, 8, 16'h0, 1'b0, -1);

    reg_write(6'h20, 16'h0000);
    peek(6'h20, v); chk("R5 cfg divider", v, 16'h0000);
    reg_write(6'h2C, 16'h0F0F);
    run_frame(1'b0, 5'h11, 5'h05, 16'h0F0F, 1, 16'h0, 1'b0, 20); // R9 start while busy

    reg_write(6'h20, 16'h0004);
    reg_write(6'h28, 16'h031F);
    reg_write(6'h24, 16'h0001);
    run_frame(1'b1, 5'h03, 5'h1F, 16'h0, 2, 16'h5AC6, 1'b0, -1);
    peek(6'h30, v); chk("R7 read data", v, 16'h5AC6);

    reg_write(6'h24, 16'h0001);
    peek(6'h34, v); chk("R8 held cmd no start", v, 0);
    @(negedge clk);
    peek(6'h34, v); chk("R8 still idle", v, 0);
    chk("R8 mdc idle", mdc, 0);
    reg_write(6'h24, 16'h0000);

    reg_write(6'h24, 16'h0001);
    run_frame(1'b1, 5'h03, 5'h1F, 16'h0, 2, 16'h0, 1'b1, -1);
    peek(6'h30, v); chk("R7 absent phy all ones", v, 16'hFFFF);
    reg_write(6'h24, 16'h0000);

    reg_write(6'h2C, 16'h7777);
    repeat (10) @(negedge clk);
    peek(6'h34, v); chk("R3 busy before abort", v, 3);
    reg_write(6'h20, 16'h8004);
    @(negedge clk);
    peek(6'h34, v); chk("R10 aborted", v, 0);
    chk("R10 mdc low", mdc, 0);
    chk("R10 oe low", mdio_oe, 0);
    reg_write(6'h2C, 16'h1111);
    peek(6'h34, v); chk("R10 start ignored", v, 0);
    @(negedge clk);
    peek(6'h34, v); chk("R10 stays idle", v, 0);
    peek(6'h20, v); chk("R10 cfg readback", v, 16'h8004);
    reg_write(6'h20, 16'h0004);
    reg_write(6'h2C, 16'hC001);
    run_frame(1'b0, 5'h03, 5'h1F, 16'hC001, 2, 16'h0, 1'b0, -1); // R10 recovery

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule